// File: doc/BRIEF.md
# Power-Down Wake Controller

This block decides when and how a small processor core leaves its halt (power-down) state. A halt request in the running state puts the block to sleep. While asleep it watches an 8-pin port and a set of interrupt request flags for a qualifying wake event. A qualifying event is a falling edge on a pin whose static wake enable is set, or an interrupt flag that was not already pending when the halt began.

After a wake event the core is held stalled for a fixed settling period of 1024 clocks. At the end of that period the block picks one of two ways to continue. It either strobes a resume-at-next-instruction pulse, or, one cycle later, strobes an interrupt dispatch with the index of the source to service. An interrupt is dispatched only when the waking source is enabled and the stack has a free level. Otherwise the core simply resumes, and the request flag stays pending for the core to service later. The CPU pipeline, the stack and the oscillators are outside this block.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset the block is running: `pwr_down`, `settling`, `resume_next` and `irq_dispatch` are all 0.
- R2: In the running state, `halt_req` = 1 at a clock edge makes `pwr_down` 1 from the next cycle, and it stays 1 until a wake event occurs.
- R3: While asleep, a high-to-low transition on `port_pins[p]` with `pin_wake_en[p]` = 1 wakes the block, and `settling` rises three clocks after the pin changes (two synchronizer stages plus edge detection). A falling edge on a pin whose enable is 0 does not wake the block, and neither does a rising edge.
- R4: While asleep, an `irq_flag` bit that was 0 at halt entry and becomes 1 wakes the block, and `settling` rises on the next clock.
- R5: An `irq_flag` bit that is already 1 when the halt is accepted never causes a wake during that power-down.
- R6: Every wake is followed by exactly 1024 consecutive cycles with `settling` = 1 and `pwr_down` = 0.
- R7: A pin-only wake ends with a one-cycle `resume_next` pulse in the cycle right after the last settling cycle.
- R8: An interrupt wake where no waking source has `irq_en` set, or where `stack_full` = 1 in the last settling cycle, ends with a `resume_next` pulse, exactly as in R7.
- R9: An interrupt wake where a waking source is enabled and `stack_full` = 0 in the last settling cycle is followed by one idle cycle with neither strobe. Then a one-cycle `irq_dispatch` pulse appears, with `irq_index` giving the source.
- R10: When several sources wake the block together, the lowest-indexed source that is enabled is dispatched. If a pin and an interrupt wake together, the interrupt rules of R8 and R9 apply.
- R11: `halt_req` is ignored during settling and during the idle cycle before a dispatch. `pwr_down` stays 0, and the settling length is unchanged.
- R12: `resume_next` and `irq_dispatch` are never high together. Each lasts one cycle, and the block is running again (with `pwr_down` = 0) in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Request to enter power-down |
| port_pins | input | 8 | Asynchronous port pin levels |
| pin_wake_en | input | 8 | Static per-pin wake enable |
| irq_flag | input | 4 | Interrupt request flags |
| irq_en | input | 4 | Per-source interrupt enables |
| stack_full | input | 1 | Stack has no free level |
| pwr_down | output | 1 | Block is in power-down |
| settling | output | 1 | Settling stall in progress |
| resume_next | output | 1 | Resume at the instruction after the halt |
| irq_dispatch | output | 1 | Dispatch the waking interrupt |
| irq_index | output | 2 | Index of the dispatched source |

## Verification
The assertions assume that `irq_en` is static across a dispatch and that `stack_full` is only read in the last settling cycle. The stimulus therefore holds both inputs constant from the wake until the strobe. They also assume that halt requests arrive only as the core would issue them. The bench raises `halt_req` in the running state only for a single cycle. Its pokes during settling and during the idle cycle are dropped before the block returns to running. Interrupt flags are cleared before each new halt unless a test means to leave one pending.

// File: rtl/pwrwake_pkg.sv
// Package: shared state encoding for the power-down wake controller.
// Assumes: nothing beyond the standard types.
package pwrwake_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_SETTLE = 2'd2,
        ST_GAP    = 2'd3
    } wake_state_t;
endpackage

// File: rtl/pin_fall_detect.sv
// Module: two-flop synchronizer and falling-edge detector, one per pin.
// Assumes: pins are asynchronous; all stages reset to 1 (idle-high port).
module pin_fall_detect #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] fall_o
);
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic s1, s2, prev;
        // Purpose: move the pin into the clock domain and remember its last level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1   <= 1'b1;
                s2   <= 1'b1;
                prev <= 1'b1;
            end else begin
                s1   <= pin_i[p];
                s2   <= s1;
                prev <= s2;
            end
        end
        // Purpose: flag a high-to-low change of the synchronized level.
        assign fall_o[p] = prev & ~s2;
    end
endmodule

// File: rtl/lowest_pick.sv
// Module: priority encoder that returns the lowest set bit of a request vector.
// Assumes: the index is meaningful only when any_o is 1.
module lowest_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // Purpose: scan from the top down so the lowest index wins.
    always_comb begin
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_i[k]) idx_o = IW'(k);
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/settle_timer.sv
// Module: counts the settling stall and flags its last cycle.
// Assumes: run_i stays high for the whole stall; SETTLE >= 2.
module settle_timer #(
    parameter int SETTLE = 1024,
    localparam int CW = $clog2(SETTLE)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    logic [CW-1:0] cnt;

    // Purpose: advance while the stall runs, otherwise return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    // Purpose: mark the final stall cycle.
    assign last_o = run_i && (cnt == CW'(SETTLE - 1));
endmodule

// File: rtl/pwr_wake_ctrl.sv
// Module: top of the power-down wake controller. Accepts a halt, waits for an
// enabled pin falling edge or a fresh interrupt flag, stalls for SETTLE clocks,
// then either resumes inline or dispatches the waking interrupt.
// Assumes: irq_en steady from wake to strobe; synchronous active-low reset.
module pwr_wake_ctrl #(
    parameter int NPIN   = 8,
    parameter int NIRQ   = 4,
    parameter int SETTLE = 1024,
    localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt_req,
    input  logic [NPIN-1:0] port_pins,
    input  logic [NPIN-1:0] pin_wake_en,
    input  logic [NIRQ-1:0] irq_flag,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            stack_full,
    output logic            pwr_down,
    output logic            settling,
    output logic            resume_next,
    output logic            irq_dispatch,
    output logic [IW-1:0]   irq_index
);
    import pwrwake_pkg::*;

    wake_state_t     state;
    logic [NIRQ-1:0] halt_mask;
    logic [NIRQ-1:0] woke_irq;
    logic [IW-1:0]   disp_idx;
    logic [NPIN-1:0] pin_fall;
    logic [NIRQ-1:0] fresh_irq;
    logic            wake;
    logic            settle_last;
    logic            pick_any;
    logic [IW-1:0]   pick_idx;
    logic            go_disp;

    pin_fall_detect #(.NPIN(NPIN)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (port_pins),
        .fall_o (pin_fall)
    );

    settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state == ST_SETTLE),
        .last_o (settle_last)
    );

    lowest_pick #(.N(NIRQ), .IW(IW)) u_pick (
        .req_i (woke_irq & irq_en),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    // Purpose: qualify wake sources; flags pending at halt entry are masked.
    always_comb begin
        fresh_irq = irq_flag & ~halt_mask;
        wake      = (state == ST_SLEEP) && ((|(pin_fall & pin_wake_en)) || (|fresh_irq));
        go_disp   = pick_any && !stack_full;
    end

    // Purpose: sequence run, sleep, settle and dispatch gap; produce strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_RUN;
            halt_mask    <= '0;
            woke_irq     <= '0;
            disp_idx     <= '0;
            resume_next  <= 1'b0;
            irq_dispatch <= 1'b0;
            irq_index    <= '0;
        end else begin
            resume_next  <= 1'b0;
            irq_dispatch <= 1'b0;
            unique case (state)
                ST_RUN: begin
                    if (halt_req) begin
                        state     <= ST_SLEEP;
                        halt_mask <= irq_flag;
                    end
                end
                ST_SLEEP: begin
                    if (wake) begin
                        state    <= ST_SETTLE;
                        woke_irq <= fresh_irq;
                    end
                end
                ST_SETTLE: begin
                    if (settle_last) begin
                        if (go_disp) begin
                            state    <= ST_GAP;
                            disp_idx <= pick_idx;
                        end else begin
                            state       <= ST_RUN;
                            resume_next <= 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    state        <= ST_RUN;
                    irq_dispatch <= 1'b1;
                    irq_index    <= disp_idx;
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // Purpose: expose the state as flags.
    assign pwr_down = (state == ST_SLEEP);
    assign settling = (state == ST_SETTLE);
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
// Module: property checker for the wake controller, bound to the top.
// Assumes: irq_en and stack_full behave as the brief's verification section states.
module pwr_wake_ctrl_chk #(
    parameter int NIRQ   = 4,
    parameter int SETTLE = 1024,
    localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1,
    localparam int CW = $clog2(SETTLE) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            halt_req,
    input logic [NIRQ-1:0] irq_en,
    input logic            stack_full,
    input logic            pwr_down,
    input logic            settling,
    input logic            resume_next,
    input logic            irq_dispatch,
    input logic [IW-1:0]   irq_index
);
    logic [CW-1:0] stall_cnt;

    // Purpose: count settling cycles since the last power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) stall_cnt <= '0;
        else if (settling)      stall_cnt <= stall_cnt + 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !pwr_down && !settling && !resume_next && !irq_dispatch); // R1
    AST_HALT_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n) !pwr_down && !settling && !resume_next && !irq_dispatch && $past(!settling) && halt_req |=> pwr_down); // R2
    AST_SETTLE_EXACT: assert property (@(posedge clk) disable iff (!rst_n) resume_next |-> stall_cnt == CW'(SETTLE)); // R6
    AST_DISP_LEN: assert property (@(posedge clk) disable iff (!rst_n) irq_dispatch |-> stall_cnt == CW'(SETTLE) && $past(!settling)); // R9
    AST_DISP_STACK: assert property (@(posedge clk) disable iff (!rst_n) irq_dispatch |-> !$past(stack_full, 2)); // R9
    AST_DISP_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) irq_dispatch |-> (($past(irq_en, 2) >> irq_index) & NIRQ'(1)) != '0); // R10
    AST_HALT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) settling && halt_req |=> !pwr_down); // R11
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(resume_next && irq_dispatch)); // R12
    AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n) resume_next |=> !resume_next); // R12
    AST_DISP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq_dispatch |=> !irq_dispatch); // R12
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.NIRQ(NIRQ), .SETTLE(SETTLE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_req     (halt_req),
    .irq_en       (irq_en),
    .stack_full   (stack_full),
    .pwr_down     (pwr_down),
    .settling     (settling),
    .resume_next  (resume_next),
    .irq_dispatch (irq_dispatch),
    .irq_index    (irq_index)
);

// File: tb/pwr_wake_ctrl_bench.sv
module pwr_wake_ctrl_bench;
    localparam int SETTLE = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0;
    logic [7:0] port_pins = 8'hFF;
    logic [7:0] pin_wake_en = 8'h00;
    logic [3:0] irq_flag = 4'h0;
    logic [3:0] irq_en = 4'h0;
    logic       stack_full = 1'b0;
    logic       pwr_down, settling, resume_next, irq_dispatch;
    logic [1:0] irq_index;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    pwr_wake_ctrl u_pwr_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .port_pins(port_pins),
        .pin_wake_en(pin_wake_en), .irq_flag(irq_flag), .irq_en(irq_en),
        .stack_full(stack_full), .pwr_down(pwr_down), .settling(settling),
        .resume_next(resume_next), .irq_dispatch(irq_dispatch), .irq_index(irq_index)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Enter power-down with a one-cycle halt request (R2).
    task automatic do_halt();
        @(negedge clk) halt_req = 1'b1;
        @(negedge clk) halt_req = 1'b0;
        check(pwr_down == 1'b1, "R2 halt enters power-down", int'(pwr_down), 1);
    endtask

    // Follow a wake started just after a negedge; dispatch when exp_disp.
    task automatic run_wake(input int exp_lat, input bit exp_disp, input int exp_idx, input string tag);
        int lat = 0;
        int len = 1;
        while (!settling && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, {tag, " wake latency"}, lat, exp_lat);
        while (len < 3000) begin
            @(negedge clk);
            if (len == 500) halt_req = 1'b1;     // R11 poke during settling
            if (len == 503) halt_req = 1'b0;
            if (!settling) break;
            check(pwr_down == 1'b0, "R11 halt ignored while settling", int'(pwr_down), 0);
            len++;
        end
        check(len == SETTLE, "R6 settling length", len, SETTLE);
        if (!exp_disp) begin
            check(resume_next && !irq_dispatch, {tag, " resume strobe"}, int'(resume_next), 1);
            check(pwr_down == 1'b0, "R12 running at strobe", int'(pwr_down), 0);
        end else begin
            check(!resume_next && !irq_dispatch, "R9 idle cycle before dispatch", int'(resume_next | irq_dispatch), 0);
            halt_req = 1'b1;                       // R11 poke during idle cycle
            @(negedge clk) halt_req = 1'b0;
            check(irq_dispatch && !resume_next, {tag, " dispatch strobe"}, int'(irq_dispatch), 1);
            check(int'(irq_index) == exp_idx, {tag, " dispatch index"}, int'(irq_index), exp_idx);
            check(pwr_down == 1'b0, "R11 halt ignored in idle cycle", int'(pwr_down), 0);
        end
        @(negedge clk);
        check(!resume_next && !irq_dispatch && !pwr_down, "R12 one-cycle strobe",
              int'(resume_next | irq_dispatch | pwr_down), 0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pwr_down && !settling && !resume_next && !irq_dispatch, "R1 reset state",
              int'({pwr_down, settling, resume_next, irq_dispatch}), 0);

        // R3 / R7: enabled pin falling edge on every pin.
        for (int p = 0; p < 8; p++) begin
            pin_wake_en = 8'(1 << p);
            do_halt();
            port_pins[p] = 1'b0;
            run_wake(3, 1'b0, 0, "R7 pin wake");
            port_pins = 8'hFF;
            repeat (4) @(negedge clk);
        end

        // R3: disabled pin falls, then rises; neither wakes. Exit via a disabled irq (R8).
        for (int p = 0; p < 8; p++) begin
            pin_wake_en = ~8'(1 << p);
            do_halt();
            port_pins[p] = 1'b0;
            repeat (8) @(negedge clk);
            check(pwr_down && !settling, "R3 disabled pin ignored", int'(pwr_down), 1);
            port_pins[p] = 1'b1;
            repeat (8) @(negedge clk);
            check(pwr_down && !settling, "R3 rising edge ignored", int'(pwr_down), 1);
            irq_en = 4'h0;
            irq_flag = 4'h1;
            run_wake(1, 1'b0, 0, "R4 irq wake");
            irq_flag = 4'h0;
        end
        pin_wake_en = 8'h00;

        // R4 / R8 / R9: every source x enable x stack state.
        for (int i = 0; i < 4; i++) begin
            for (int en = 0; en < 2; en++) begin
                for (int sf = 0; sf < 2; sf++) begin
                    irq_en = (en != 0) ? 4'(1 << i) : ~4'(1 << i);
                    stack_full = sf[0];
                    do_halt();
                    irq_flag = 4'(1 << i);
                    run_wake(1, (en != 0) && (sf == 0), i, (en != 0) ? "R9 irq" : "R8 irq");
                    irq_flag = 4'h0;
                    stack_full = 1'b0;
                end
            end
        end

        // R5: flag pending at halt does not wake; a fresh one does (index 3).
        irq_en = 4'b1010;
        irq_flag = 4'b0010;
        do_halt();
        repeat (10) @(negedge clk);
        check(pwr_down && !settling, "R5 pending flag ignored", int'(pwr_down), 1);
        irq_flag = 4'b1010;
        run_wake(1, 1'b1, 3, "R5 fresh flag");
        irq_flag = 4'h0;

        // R10: three sources together; lowest enabled (2) wins over disabled 1.
        irq_en = 4'b1100;
        do_halt();
        irq_flag = 4'b1110;
        run_wake(1, 1'b1, 2, "R10 priority");
        irq_flag = 4'h0;

        // R10: pin and disabled irq together follow the irq resume rule.
        irq_en = 4'h0;
        pin_wake_en = 8'h01;
        do_halt();
        irq_flag = 4'h4;
        port_pins[0] = 1'b0;
        run_wake(1, 1'b0, 0, "R10 pin+irq");
        irq_flag = 4'h0;
        port_pins = 8'hFF;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule